// File: doc/BRIEF.md
# Burst DMA Bus Master

This block is the bus-master end of a 32-bit DMA port whose address and data share one set of wires. Internal logic hands it a descriptor: a start address, a direction and a word count. The block checks the count, pulls its active-low bus request low and waits for the external arbiter's active-low grant. After the grant it spends one cycle driving the address, with the direction and a 3-bit burst-size code. It then moves one word each time the target strobes its active-low ready.

Write words come from internal logic over a valid/ready stream. A word is consumed on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` never depends on `wr_valid`. The upstream source must hold `wr_data` stable and `wr_valid` high until the handshake. A target ready strobe that arrives while `wr_valid` is low is not counted.

Read words leave on `rd_valid`/`rd_data` with no back-pressure, because the external bus cannot be stalled from this side. The consumer must take every beat. A transfer ends either with a `done` pulse or with an `aborted` pulse. In both cases `xfer_count` shows how many words moved.

Top module: `dma_burst_master`

## Requirements
- R1: `bus_size` carries the code for the descriptor length: 1 word = 3'b000, 2 = 3'b001, 4 = 3'b010, 8 = 3'b011, 16 = 3'b100, 12 = 3'b101. A code above 3'b101 is never driven.
- R2: `bus_dir` is 1 for a read and 0 for a write. It does not change while a transfer is in progress.
- R3: A descriptor is taken only while `req_ready` is high. `bus_req_n` goes low in the cycle after an accepted descriptor.
- R4: The address appears on `bus_ad_out`, with `bus_ad_oe` high, only in the cycle after `bus_gnt_n` is sampled low. It is driven there for exactly one cycle.
- R5: On a read, each counted ready strobe produces one `rd_valid` cycle, with the word taken from `bus_ad_in`.
- R6: On a write, the current `wr_data` is on `bus_ad_out` with `bus_ad_oe` high during the data phase. Each counted ready strobe is one `wr_valid`/`wr_ready` handshake.
- R7: `bus_req_n` is low while waiting for grant and while more than one word remains. It is high once only one word remains.
- R8: With `early_mode` = 1, a strobe on `bus_rdy_n` or `bus_abort_n` takes effect at the clock edge that ends its cycle. With `early_mode` = 0, it takes effect one clock later. `rd_valid`, `done` and `aborted` follow one cycle after that.
- R9: A descriptor length other than 1, 2, 4, 8, 12 or 16 gives a one-cycle `req_err` pulse. No bus request is made for it.
- R10: A counted abort strobe ends the transfer. The block returns to idle, releases the bus, pulses `aborted`, and sets `xfer_count` to the words already moved. An abort in the same cycle as a ready strobe wins, and that word is not counted.
- R11: After the last word, the block returns to idle, pulses `done` and sets `xfer_count` to the descriptor length.
- R12: `bus_ad_oe` is low while idle and while waiting for grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| early_mode | input | 1 | 1 = sample the ready and abort strobes one clock earlier |
| req_valid | input | 1 | Descriptor valid |
| req_ready | output | 1 | Block idle, descriptor can be taken |
| req_addr | input | 32 | Start address |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_len | input | 5 | Word count |
| req_err | output | 1 | Pulse: descriptor rejected |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word consumed this cycle |
| wr_data | input | 32 | Write word |
| rd_valid | output | 1 | Read word valid (no back-pressure) |
| rd_data | output | 32 | Read word |
| done | output | 1 | Pulse: transfer complete |
| aborted | output | 1 | Pulse: transfer aborted |
| xfer_count | output | 5 | Words moved in the last transfer |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| bus_rdy_n | input | 1 | Target ready strobe, active low |
| bus_abort_n | input | 1 | Abort strobe, active low |
| bus_dir | output | 1 | Access direction, 1 = read |
| bus_size | output | 3 | Burst-size code |
| bus_ad_out | output | 32 | Address/data driven onto the bus |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ad_in | input | 32 | Address/data received from the bus |

## Verification
A wrong remaining-word count shows at the ports as `bus_req_n` rising one strobe early or late. It also shows as `done` at the wrong beat and a wrong `xfer_count`, all within a strobe or two. A bad state register shows as `bus_ad_oe` rising without a preceding grant, or as the address cycle lasting the wrong number of cycles, on the very next clock. A wrong choice of sampling path in the strobe sampler moves `rd_valid`, `done` and `aborted` by exactly one cycle. The bench therefore samples both the cycle where each pulse belongs and the cycle one earlier.

// File: rtl/dma_bm_pkg.sv
package dma_bm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_GNT,
    ST_ADDR,
    ST_DATA
  } dma_state_e;

  // Returns {legal, size_code}; the twelve-word burst takes code 5.
  function automatic logic [3:0] size_code(input int unsigned len, input int unsigned max_len);
    logic [3:0] r;
    case (len)
      1:       r = 4'b1_000;
      2:       r = 4'b1_001;
      4:       r = 4'b1_010;
      8:       r = 4'b1_011;
      16:      r = 4'b1_100;
      12:      r = 4'b1_101;
      default: r = 4'b0_000;
    endcase
    if (len > max_len) r = 4'b0_000;
    return r;
  endfunction

endpackage

// File: rtl/dma_strobe_sample.sv
module dma_strobe_sample #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early,
  input  logic              in_phase,
  input  logic              rdy_n,
  input  logic              abt_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rdy,
  output logic              abt,
  output logic [DATA_W-1:0] data
);
  logic              rdy_q, abt_q;
  logic [DATA_W-1:0] ad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      abt_q <= 1'b0;
      ad_q  <= '0;
    end else begin
      rdy_q <= in_phase & ~rdy_n;
      abt_q <= in_phase & ~abt_n;
      ad_q  <= ad_in;
    end
  end

  // Early mode uses the live pins; normal mode uses last cycle's sample.
  assign rdy  = in_phase & (early ? ~rdy_n : rdy_q);
  assign abt  = in_phase & (early ? ~abt_n : abt_q);
  assign data = early ? ad_in : ad_q;
endmodule

// File: rtl/dma_word_ctr.sv
module dma_word_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] remain,
  output logic             last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain <= '0;
    else if (load) remain <= load_val;
    else if (dec)  remain <= remain - CNT_W'(1);
  end

  assign last = (remain == CNT_W'(1));
endmodule

// File: rtl/dma_burst_master.sv
module dma_burst_master
  import dma_bm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 16,
  localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rd,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_err,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              aborted,
  output logic [LEN_W-1:0]  xfer_count,
  output logic              bus_req_n,
  input  logic              bus_gnt_n,
  input  logic              bus_rdy_n,
  input  logic              bus_abort_n,
  output logic              bus_dir,
  output logic [2:0]        bus_size,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_ad_in
);
  dma_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              dir_q;
  logic [LEN_W-1:0]  len_q;
  logic [2:0]        code_q;
  logic [3:0]        chk;
  logic              desc_ok, idle, accept_ok, bad_req;
  logic              in_data, in_addr;
  logic              smp_rdy, smp_abt;
  logic [DATA_W-1:0] smp_data;
  logic              word_move, abort_hit, finish;
  logic [LEN_W-1:0]  remain;
  logic              ctr_last;
  logic              done_q, aborted_q, err_q, rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [LEN_W-1:0]  count_q;

  assign chk       = size_code(int'(req_len), MAX_BURST);
  assign desc_ok   = chk[3];
  assign idle      = (state_q == ST_IDLE);
  assign in_addr   = (state_q == ST_ADDR);
  assign in_data   = (state_q == ST_DATA);
  assign accept_ok = req_valid & idle & desc_ok;
  assign bad_req   = req_valid & idle & ~desc_ok;

  dma_strobe_sample #(.DATA_W(DATA_W)) i_sample (
    .clk(clk), .rst_n(rst_n), .early(early_mode), .in_phase(in_data),
    .rdy_n(bus_rdy_n), .abt_n(bus_abort_n), .ad_in(bus_ad_in),
    .rdy(smp_rdy), .abt(smp_abt), .data(smp_data)
  );

  assign abort_hit = smp_abt;
  assign word_move = smp_rdy & ~smp_abt & (dir_q | wr_valid);
  assign finish    = word_move & ctr_last;

  dma_word_ctr #(.CNT_W(LEN_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .load(accept_ok), .load_val(req_len),
    .dec(word_move), .remain(remain), .last(ctr_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (accept_ok)            state_d = ST_WAIT_GNT;
      ST_WAIT_GNT: if (!bus_gnt_n)           state_d = ST_ADDR;
      ST_ADDR:                               state_d = ST_DATA;
      ST_DATA:     if (abort_hit || finish)  state_d = ST_IDLE;
      default:                               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      dir_q      <= 1'b0;
      len_q      <= '0;
      code_q     <= 3'b000;
      done_q     <= 1'b0;
      aborted_q  <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      count_q    <= '0;
    end else begin
      state_q    <= state_d;
      done_q     <= finish;
      aborted_q  <= abort_hit;
      err_q      <= bad_req;
      rd_valid_q <= word_move & dir_q;
      if (word_move && dir_q) rd_data_q <= smp_data;
      if (accept_ok) begin
        addr_q <= req_addr;
        dir_q  <= req_rd;
        len_q  <= req_len;
        code_q <= chk[2:0];
      end
      if (finish)         count_q <= len_q;
      else if (abort_hit) count_q <= len_q - remain;
    end
  end

  assign req_ready  = idle;
  assign req_err    = err_q;
  assign wr_ready   = smp_rdy & ~smp_abt & ~dir_q;
  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign done       = done_q;
  assign aborted    = aborted_q;
  assign xfer_count = count_q;
  assign bus_req_n  = ~((state_q == ST_WAIT_GNT) | ((in_addr | in_data) & ~ctr_last));
  assign bus_dir    = dir_q;
  assign bus_size   = code_q;
  assign bus_ad_oe  = in_addr | (in_data & ~dir_q);
  assign bus_ad_out = in_addr ? DATA_W'(addr_q) : ((in_data & ~dir_q) ? wr_data : '0);
endmodule

// File: rtl/dma_bm_chk.sv
module dma_bm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       req_err,
  input logic       done,
  input logic       aborted,
  input logic       bus_req_n,
  input logic       bus_gnt_n,
  input logic       bus_ad_oe,
  input logic       bus_dir,
  input logic [2:0] bus_size,
  input logic       last_word,
  input logic       in_data
);
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (bus_size <= 3'd5)); // R1
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(bus_dir)); // R2
  AST_ADDR_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ad_oe) |-> $past(!bus_gnt_n)); // R4
  AST_REQ_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && last_word) |-> bus_req_n); // R7
  AST_REJECT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (bus_req_n && req_ready)); // R9
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> (req_ready && !bus_ad_oe && bus_req_n)); // R10
  AST_ONE_END_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, aborted, req_err})); // R10
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !bus_ad_oe && bus_req_n)); // R11
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || !bus_gnt_n && !bus_req_n && !bus_ad_oe) |-> !bus_ad_oe); // R12
endmodule

bind dma_burst_master dma_bm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .done(done), .aborted(aborted), .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n),
  .bus_ad_oe(bus_ad_oe), .bus_dir(bus_dir), .bus_size(bus_size),
  .last_word(ctr_last), .in_data(in_data)
);

// File: tb/test_dma_burst_master.sv
`timescale 1ns/1ps
module test_dma_burst_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        early_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_rd = 1'b0;
  logic [4:0]  req_len = '0;
  logic        req_err;
  logic        wr_valid = 1'b1;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        done, aborted;
  logic [4:0]  xfer_count;
  logic        bus_req_n;
  logic        bus_gnt_n = 1'b1;
  logic        bus_rdy_n = 1'b1;
  logic        bus_abort_n = 1'b1;
  logic        bus_dir;
  logic [2:0]  bus_size;
  logic [31:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [31:0] bus_ad_in = '0;

  int total = 0;
  int bad = 0;
  int wr_hs = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  dma_burst_master i_dma_burst_master (.*);

  // Observation only: count write handshakes seen at the port.
  always @(posedge clk) if (wr_valid && wr_ready) wr_hs <= wr_hs + 1;

  // {early, rd, len}
  localparam logic [6:0] VEC [8] = '{
    {1'b0, 1'b1, 5'd1},  {1'b1, 1'b1, 5'd2},  {1'b0, 1'b0, 5'd4},  {1'b1, 1'b0, 5'd8},
    {1'b0, 1'b1, 5'd12}, {1'b1, 1'b1, 5'd16}, {1'b0, 1'b0, 5'd16}, {1'b1, 1'b0, 5'd12}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input int len);
    case (len)
      1: return 3'd0; 2: return 3'd1; 4: return 3'd2;
      8: return 3'd3; 16: return 3'd4; 12: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int len, input int k);
    return 32'hA500_0000 ^ (32'(len) << 8) ^ 32'(k);
  endfunction

  task automatic start_xfer(input bit early, input bit rd, input int len);
    logic [31:0] addr;
    addr = 32'h1000_0000 + 32'(len) * 32'd64;
    @(negedge clk);
    early_mode = early; req_valid = 1'b1; req_addr = addr; req_rd = rd; req_len = 5'(len);
    wr_data = pat(len, 0);
    chk("R3 ready before accept", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 request after accept", 32'(bus_req_n), 32'd0);
    chk("R12 no drive waiting grant", 32'(bus_ad_oe), 32'd0);
    @(negedge clk);
    chk("R12 no drive without grant", 32'(bus_ad_oe), 32'd0);
    bus_gnt_n = 1'b0;
    @(negedge clk);
    bus_gnt_n = 1'b1;
    chk("R4 address enable", 32'(bus_ad_oe), 32'd1);
    chk("R4 address value", bus_ad_out, addr);
    chk("R1 size code", 32'(bus_size), 32'(exp_code(len)));
    chk("R2 direction", 32'(bus_dir), 32'(rd));
    chk("R7 request in address cycle", 32'(bus_req_n), (len > 1) ? 32'd0 : 32'd1);
  endtask

  task automatic do_xfer(input bit early, input bit rd, input int len);
    int hs0;
    hs0 = wr_hs;
    start_xfer(early, rd, len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk("R7 request vs remaining", 32'(bus_req_n), (len - k > 1) ? 32'd0 : 32'd1);
      if (!rd) begin
        chk("R6 write data on bus", bus_ad_out, pat(len, k));
        chk("R6 write drive", 32'(bus_ad_oe), 32'd1);
      end else begin
        chk("R4 read releases bus", 32'(bus_ad_oe), 32'd0);
        bus_ad_in = pat(len, k);
      end
      bus_rdy_n = 1'b0;
      @(negedge clk);
      bus_rdy_n = 1'b1;
      bus_ad_in = 32'hDEAD_BEEF;
      if (early) begin
        chk("R5 R8 early read beat", 32'(rd_valid), 32'(rd));
        if (rd) chk("R5 read data", rd_data, pat(len, k));
        chk("R11 R8 early done", 32'(done), (k == len - 1) ? 32'd1 : 32'd0);
      end else begin
        chk("R8 normal no beat yet", 32'(rd_valid), 32'd0);
        chk("R8 normal no done yet", 32'(done), 32'd0);
      end
      @(negedge clk);
      if (!early) begin
        chk("R5 R8 normal read beat", 32'(rd_valid), 32'(rd));
        if (rd) chk("R5 read data", rd_data, pat(len, k));
        chk("R11 R8 normal done", 32'(done), (k == len - 1) ? 32'd1 : 32'd0);
      end else begin
        chk("R5 single beat", 32'(rd_valid), 32'd0);
      end
      wr_data = pat(len, k + 1);
    end
    chk("R11 count", 32'(xfer_count), 32'(len));
    chk("R11 idle after done", 32'(req_ready), 32'd1);
    chk("R12 bus released", 32'(bus_ad_oe), 32'd0);
    chk("R6 write handshakes", 32'(wr_hs - hs0), rd ? 32'd0 : 32'(len));
  endtask

  task automatic do_abort(input bit early);
    start_xfer(early, 1'b1, 8);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); bus_rdy_n = 1'b0;
      @(negedge clk); bus_rdy_n = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    bus_abort_n = 1'b0;
    bus_rdy_n = 1'b0;                 // same-cycle ready loses to abort
    @(negedge clk);
    bus_abort_n = 1'b1;
    bus_rdy_n = 1'b1;
    if (!early) begin
      chk("R8 normal abort not yet", 32'(aborted), 32'd0);
      @(negedge clk);
    end
    chk("R10 aborted pulse", 32'(aborted), 32'd1);
    chk("R10 no beat on abort", 32'(rd_valid), 32'd0);
    chk("R10 words done", 32'(xfer_count), 32'd3);
    chk("R10 idle", 32'(req_ready), 32'd1);
    chk("R10 request released", 32'(bus_req_n), 32'd1);
    chk("R10 bus released", 32'(bus_ad_oe), 32'd0);
    @(negedge clk);
    chk("R10 single pulse", 32'(aborted), 32'd0);
  endtask

  task automatic bad_len(input int len);
    @(negedge clk);
    req_valid = 1'b1; req_len = 5'(len); req_rd = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 error pulse", 32'(req_err), 32'd1);
    chk("R9 no request", 32'(bus_req_n), 32'd1);
    @(negedge clk);
    chk("R9 error single", 32'(req_err), 32'd0);
    chk("R9 stays idle", 32'(req_ready), 32'd1);
    chk("R9 still no request", 32'(bus_req_n), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset ready", 32'(req_ready), 32'd1);
    chk("R7 reset request high", 32'(bus_req_n), 32'd1);
    chk("R12 reset no drive", 32'(bus_ad_oe), 32'd0);
    chk("R11 reset no done", 32'(done), 32'd0);
    for (int v = 0; v < 8; v++)
      do_xfer(VEC[v][6], VEC[v][5], int'(VEC[v][4:0]));
    bad_len(3);
    bad_len(0);
    bad_len(31);
    do_abort(1'b0);
    do_abort(1'b1);
    do_xfer(1'b0, 1'b1, 2);
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule